// File: doc/BRIEF.md
# Delayed-Write Bus Target Controller

This block is the write-acceptance engine of a bus target. Every cycle it sees at most one offered data phase from a bus master. For each write phase it claims, it answers in the same cycle with one of four results: accept, retry, disconnect without data, or disconnect with data. Accepted or latched data goes into a write queue. The command and address of each new transaction go into an address queue. The user side drains both queues.

A static active-low mode input selects the delayed policy for I/O writes. With that policy, the first I/O write attempt is not accepted. Its command, address, first data word and byte enables are captured, and the master is told to retry. After the user side has consumed the captured word, an identical retry is accepted with a disconnect-with-data, which closes the transaction. A discard counter abandons a captured request that is never completed. Memory writes, and I/O writes when delayed mode is off, stream straight into the write queue.

Top module: `dwr_target_ctrl`

## Requirements
- R1: After reset, `treq_n` is 1, both queues are empty, `tmr_expired` is 0, and no response output is high.
- R2: When delayed mode is off, a write phase starts a streaming transaction. This applies to memory write commands (code 4'h7), and to I/O write commands (code 4'h3) when `delay_mode_n` is 1. The first phase must have `ph_first`=1. Each such phase is answered with `bus_accept`, and the queues receive the word and byte enables in bus order. The first phase also pushes {command, address} into the address queue.
- R3: While a streaming transaction is open and the write queue is full, the next phase is answered with `bus_disc_nodata`, and nothing is pushed.
- R4: A streaming transaction ends at an accepted phase with `ph_last`=1, or at a disconnect without data. After it ends, every write attempt is retried until the write queue is completely empty, even if the queue has been partly drained. The next write after that is a new transaction and pushes a new address entry.
- R5: `treq_n` goes low in the cycle after the first phase of a transaction is accepted or captured. For a streaming write, it returns high in the cycle after the write queue becomes empty once the transaction has ended.
- R6: When `delay_mode_n` is 0, the first I/O write attempt is answered with `bus_retry`. That attempt pushes {command, address} into the address queue and {byte enables, data} into the write queue, and it drives `treq_n` low.
- R7: While the captured word is still in the write queue (request state), every write attempt is retried, including an attempt that matches the captured request.
- R8: Once the user side has emptied the write queue (completion state), an I/O write whose command, address, data and byte enables all equal the captured values is answered with `bus_disc_data`. On the next cycle both queues are empty and `treq_n` is 1.
- R9: In the completion state, a non-matching write is retried and leaves the captured request unchanged. A later matching write still completes.
- R10: `tmr_expired` is high for exactly one cycle, the cycle after the (2^TMR_W−2)-th edge following the capture edge, unless the request completes first. At the next edge the controller returns to idle with both queues empty and `treq_n` high. A later identical I/O write is then captured as a new request.
- R11: Phases whose command is neither 4'h3 nor 4'h7 get no response and push nothing.
- R12: With `delay_mode_n` at 0, memory writes are still handled as streaming writes under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| delay_mode_n | input | 1 | Static; 0 selects delayed handling of I/O writes |
| ph_valid | input | 1 | A data phase is offered this cycle |
| ph_first | input | 1 | Phase is the first of a transaction (carries command/address) |
| ph_last | input | 1 | Master's final data phase |
| ph_cmd | input | 4 | Bus command code |
| ph_addr | input | ADDR_W | Transaction address |
| ph_data | input | DATA_W | Phase data |
| ph_be | input | DATA_W/8 | Phase byte enables |
| bus_accept | output | 1 | Phase data taken |
| bus_retry | output | 1 | Attempt terminated with retry |
| bus_disc_nodata | output | 1 | Disconnect, phase data not taken |
| bus_disc_data | output | 1 | Disconnect, phase data taken (delayed completion) |
| usr_wpop | input | 1 | User pops the write queue head |
| usr_wvalid | output | 1 | Write queue not empty |
| usr_wdata | output | DATA_W | Write queue head data |
| usr_wbe | output | DATA_W/8 | Write queue head byte enables |
| usr_apop | input | 1 | User pops the address queue head |
| usr_avalid | output | 1 | Address queue not empty |
| usr_acmd | output | 4 | Address queue head command |
| usr_aaddr | output | ADDR_W | Address queue head address |
| treq_n | output | 1 | Active-low target request to the user side |
| tmr_expired | output | 1 | One-cycle discard-timeout pulse |

## Verification
The assertions assume that `delay_mode_n` stays static between resets. They also assume that the user side pops only when the matching valid output is high. The stimulus changes the mode only while the controller is idle, and the user-side monitor pops only non-empty queues. A scoreboard keeps the expected queue contents in order. Captured delayed words are compared in the same way as streamed ones. The discard window is counted edge by edge from the capture edge.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  localparam logic [3:0] CMD_IO_WR  = 4'h3;
  localparam logic [3:0] CMD_MEM_WR = 4'h7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ND_BUS,
    ST_ND_DRAIN,
    ST_DW_REQ,
    ST_DW_CMP
  } tgt_state_e;

  typedef enum logic [2:0] {
    RSP_NONE,
    RSP_ACCEPT,
    RSP_RETRY,
    RSP_DISC_NODATA,
    RSP_DISC_DATA
  } rsp_e;
endpackage

// File: rtl/dwt_fifo.sv
module dwt_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  input  logic         clr,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rd_q];

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    cnt_n = cnt_q;
    if (clr) begin
      rd_n  = '0;
      wr_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_n = (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
      cnt_n = cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  // R3
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> !full);
endmodule

// File: rtl/dwt_discard_timer.sv
module dwt_discard_timer #(
  parameter int TW = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic hit
);
  localparam logic [TW-1:0] LIMIT = {{(TW-1){1'b1}}, 1'b0};

  logic [TW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign cnt_en = start || run;

  always_comb begin
    cnt_n = start ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign hit = run && (cnt_q == LIMIT);

  // R10
  timer_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !hit);
endmodule

// File: rtl/dwr_target_ctrl.sv
module dwr_target_ctrl
  import dwt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int WDEPTH = 4,
  parameter int ADEPTH = 2,
  parameter int TMR_W  = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                delay_mode_n,
  input  logic                ph_valid,
  input  logic                ph_first,
  input  logic                ph_last,
  input  logic [3:0]          ph_cmd,
  input  logic [ADDR_W-1:0]   ph_addr,
  input  logic [DATA_W-1:0]   ph_data,
  input  logic [DATA_W/8-1:0] ph_be,
  output logic                bus_accept,
  output logic                bus_retry,
  output logic                bus_disc_nodata,
  output logic                bus_disc_data,
  input  logic                usr_wpop,
  output logic                usr_wvalid,
  output logic [DATA_W-1:0]   usr_wdata,
  output logic [DATA_W/8-1:0] usr_wbe,
  input  logic                usr_apop,
  output logic                usr_avalid,
  output logic [3:0]          usr_acmd,
  output logic [ADDR_W-1:0]   usr_aaddr,
  output logic                treq_n,
  output logic                tmr_expired
);
  localparam int BE_W = DATA_W / 8;
  localparam int WQ_W = DATA_W + BE_W;
  localparam int AQ_W = ADDR_W + 4;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  tgt_state_e state_q, state_n;
  rsp_e       rsp;

  logic [3:0]        m_cmd_q;
  logic [ADDR_W-1:0] m_addr_q;
  logic [DATA_W-1:0] m_data_q;
  logic [BE_W-1:0]   m_be_q;

  logic is_wr, is_dly, claim, req_match, cmp_hit;
  logic wpush, apush, qclr, latch, tmr_hit, busy, expire;
  logic wempty, wfull, aempty, afull;

  assign is_wr     = (ph_cmd == CMD_IO_WR) || (ph_cmd == CMD_MEM_WR);
  assign is_dly    = (ph_cmd == CMD_IO_WR) && !delay_mode_n;
  assign claim     = ph_valid && is_wr;
  assign req_match = (ph_cmd == m_cmd_q) && (ph_addr == m_addr_q) &&
                     (ph_data == m_data_q) && (ph_be == m_be_q);
  assign cmp_hit   = (state_q == ST_DW_CMP) && claim && is_dly && req_match;
  assign busy      = (state_q == ST_DW_REQ) || (state_q == ST_DW_CMP);
  assign expire    = tmr_hit && !cmp_hit;

  always_comb begin
    state_n = state_q;
    rsp     = RSP_NONE;
    wpush   = 1'b0;
    apush   = 1'b0;
    qclr    = 1'b0;
    latch   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (claim) begin
          if (!ph_first || afull) begin
            rsp = RSP_RETRY;
          end else if (is_dly) begin
            rsp     = RSP_RETRY;
            wpush   = 1'b1;
            apush   = 1'b1;
            latch   = 1'b1;
            state_n = ST_DW_REQ;
          end else begin
            rsp     = RSP_ACCEPT;
            wpush   = 1'b1;
            apush   = 1'b1;
            state_n = ph_last ? ST_ND_DRAIN : ST_ND_BUS;
          end
        end
      end
      ST_ND_BUS: begin
        if (claim) begin
          if (wfull) begin
            rsp     = RSP_DISC_NODATA;
            state_n = ST_ND_DRAIN;
          end else begin
            rsp   = RSP_ACCEPT;
            wpush = 1'b1;
            if (ph_last) state_n = ST_ND_DRAIN;
          end
        end
      end
      ST_ND_DRAIN: begin
        if (claim)  rsp = RSP_RETRY;
        if (wempty) state_n = ST_IDLE;
      end
      ST_DW_REQ: begin
        if (claim) rsp = RSP_RETRY;
        if (expire) begin
          qclr    = 1'b1;
          state_n = ST_IDLE;
        end else if (wempty) begin
          state_n = ST_DW_CMP;
        end
      end
      ST_DW_CMP: begin
        if (cmp_hit) begin
          rsp     = RSP_DISC_DATA;
          qclr    = 1'b1;
          state_n = ST_IDLE;
        end else begin
          if (claim) rsp = RSP_RETRY;
          if (expire) begin
            qclr    = 1'b1;
            state_n = ST_IDLE;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      m_cmd_q  <= '0;
      m_addr_q <= '0;
      m_data_q <= '0;
      m_be_q   <= '0;
    end else if (latch) begin
      m_cmd_q  <= ph_cmd;
      m_addr_q <= ph_addr;
      m_data_q <= ph_data;
      m_be_q   <= ph_be;
    end
  end

  assign bus_accept      = (rsp == RSP_ACCEPT);
  assign bus_retry       = (rsp == RSP_RETRY);
  assign bus_disc_nodata = (rsp == RSP_DISC_NODATA);
  assign bus_disc_data   = (rsp == RSP_DISC_DATA);
  assign treq_n          = (state_q == ST_IDLE);
  assign tmr_expired     = busy && expire;

  logic [WQ_W-1:0] wq_out;
  logic [AQ_W-1:0] aq_out;

  dwt_fifo #(.W(WQ_W), .DEPTH(WDEPTH)) u_wq (
    .clk(clk), .rst_n(rst_sync_n), .push(wpush), .din({ph_be, ph_data}),
    .pop(usr_wpop), .clr(qclr), .dout(wq_out), .empty(wempty), .full(wfull));

  dwt_fifo #(.W(AQ_W), .DEPTH(ADEPTH)) u_aq (
    .clk(clk), .rst_n(rst_sync_n), .push(apush), .din({ph_cmd, ph_addr}),
    .pop(usr_apop), .clr(qclr), .dout(aq_out), .empty(aempty), .full(afull));

  dwt_discard_timer #(.TW(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .start(latch), .run(busy), .hit(tmr_hit));

  assign {usr_wbe, usr_wdata} = wq_out;
  assign {usr_acmd, usr_aaddr} = aq_out;
  assign usr_wvalid = !wempty;
  assign usr_avalid = !aempty;

  // R1
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({bus_accept, bus_retry, bus_disc_nodata, bus_disc_data}));

  // R3
  nodata_when_full_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_disc_nodata |-> (wfull && !wpush));

  // R7
  dwr_retry_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (claim && !treq_n && !wempty && !busy == 1'b0 && state_q == ST_DW_REQ) |-> bus_retry);

  // R8
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_disc_data |=> (treq_n && !usr_wvalid && !usr_avalid));

  // R10
  expire_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tmr_expired |=> (treq_n && !usr_wvalid && !usr_avalid && !tmr_expired));

  // R6
  latch_treq_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (treq_n && bus_retry && wpush) |=> (!treq_n && usr_wvalid));
endmodule

// File: tb/tb_dwr_target_ctrl.sv
module tb_dwr_target_ctrl;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int ADDR_W = 32;
  localparam int TMR_W  = 15;
  localparam int EXP_K  = (1 << TMR_W) - 2;

  localparam int R_NONE = 0, R_ACC = 1, R_RTY = 2, R_DND = 3, R_DD = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic delay_mode_n;
  logic ph_valid, ph_first, ph_last;
  logic [3:0] ph_cmd;
  logic [ADDR_W-1:0] ph_addr;
  logic [DATA_W-1:0] ph_data;
  logic [BE_W-1:0] ph_be;
  logic bus_accept, bus_retry, bus_disc_nodata, bus_disc_data;
  logic usr_wpop, usr_wvalid, usr_apop, usr_avalid;
  logic [DATA_W-1:0] usr_wdata;
  logic [BE_W-1:0] usr_wbe;
  logic [3:0] usr_acmd;
  logic [ADDR_W-1:0] usr_aaddr;
  logic treq_n, tmr_expired;

  int total = 0;
  int bad = 0;
  bit drain_en = 1'b0;
  logic [DATA_W+BE_W-1:0] exp_wq[$];
  logic [ADDR_W+3:0] exp_aq[$];

  always #5 clk = ~clk;

  dwr_target_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMR_W(TMR_W)) dut (
    .clk(clk), .rst_n(rst_n), .delay_mode_n(delay_mode_n),
    .ph_valid(ph_valid), .ph_first(ph_first), .ph_last(ph_last),
    .ph_cmd(ph_cmd), .ph_addr(ph_addr), .ph_data(ph_data), .ph_be(ph_be),
    .bus_accept(bus_accept), .bus_retry(bus_retry),
    .bus_disc_nodata(bus_disc_nodata), .bus_disc_data(bus_disc_data),
    .usr_wpop(usr_wpop), .usr_wvalid(usr_wvalid), .usr_wdata(usr_wdata),
    .usr_wbe(usr_wbe), .usr_apop(usr_apop), .usr_avalid(usr_avalid),
    .usr_acmd(usr_acmd), .usr_aaddr(usr_aaddr), .treq_n(treq_n),
    .tmr_expired(tmr_expired));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int resp_code();
    if (bus_accept)      return R_ACC;
    if (bus_retry)       return R_RTY;
    if (bus_disc_nodata) return R_DND;
    if (bus_disc_data)   return R_DD;
    return R_NONE;
  endfunction

  // scoreboard monitor: user side pops and compares
  always @(negedge clk) begin
    usr_wpop = 1'b0;
    usr_apop = 1'b0;
    if (drain_en && rst_n) begin
      if (usr_wvalid) begin
        if (exp_wq.size() == 0) chk(1'b0, "R2 unexpected word", 64'(usr_wdata), 0);
        else begin
          logic [DATA_W+BE_W-1:0] e;
          e = exp_wq.pop_front();
          chk({usr_wbe, usr_wdata} == e, "R2 word order", 64'({usr_wbe, usr_wdata}), 64'(e));
        end
        usr_wpop = 1'b1;
      end
      if (usr_avalid) begin
        if (exp_aq.size() == 0) chk(1'b0, "R2 unexpected addr", 64'(usr_aaddr), 0);
        else begin
          logic [ADDR_W+3:0] ea;
          ea = exp_aq.pop_front();
          chk({usr_acmd, usr_aaddr} == ea, "R2 addr entry", 64'({usr_acmd, usr_aaddr}), 64'(ea));
        end
        usr_apop = 1'b1;
      end
    end
  end

  // driver: one data phase, response checked mid-cycle, expectations queued
  task automatic phase(input logic [3:0] c, input logic [31:0] a, input logic [31:0] d,
                       input logic [3:0] b, input bit f, input bit l, input int expr,
                       input bit qw, input bit qa, input string req);
    @(negedge clk);
    ph_valid = 1'b1; ph_cmd = c; ph_addr = a; ph_data = d; ph_be = b;
    ph_first = f; ph_last = l;
    #1;
    chk(resp_code() == expr, req, 64'(resp_code()), 64'(expr));
    if (qw) exp_wq.push_back({b, d});
    if (qa) exp_aq.push_back({c, a});
    @(posedge clk);
    #1;
    ph_valid = 1'b0; ph_first = 1'b0; ph_last = 1'b0;
  endtask

  task automatic drain_all();
    drain_en = 1'b1;
    repeat (12) @(posedge clk);
    #1;
    drain_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; delay_mode_n = 1'b1; ph_valid = 1'b0; ph_first = 1'b0;
    ph_last = 1'b0; ph_cmd = '0; ph_addr = '0; ph_data = '0; ph_be = '0;
    usr_wpop = 1'b0; usr_apop = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(treq_n == 1'b1, "R1 treq_n", 64'(treq_n), 1);
    chk(!usr_wvalid && !usr_avalid, "R1 queues empty", 64'({usr_wvalid, usr_avalid}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk(resp_code() == R_NONE && !tmr_expired, "R1 outputs idle", 64'(resp_code()), 0);

    // R2/R5 streaming memory burst of three
    phase(4'h7, 32'h1000, 32'hA0, 4'hF, 1, 0, R_ACC, 1, 1, "R2 burst p1");
    chk(treq_n == 1'b0, "R5 treq low", 64'(treq_n), 0);
    phase(4'h7, 32'h1000, 32'hA1, 4'h3, 0, 0, R_ACC, 1, 0, "R2 burst p2");
    phase(4'h7, 32'h1000, 32'hA2, 4'hC, 0, 1, R_ACC, 1, 0, "R2 burst p3");
    // R4 retried until queue empty
    phase(4'h7, 32'h2000, 32'hB0, 4'hF, 1, 1, R_RTY, 0, 0, "R4 retry while draining");
    drain_all();
    chk(treq_n == 1'b1, "R5 treq high after drain", 64'(treq_n), 1);

    // R3 fill and disconnect without data
    for (int i = 0; i < 4; i++)
      phase(4'h7, 32'h3000, 32'hC0 + 32'(i), 4'hF, i == 0, 0, R_ACC, 1, i == 0, "R2 fill");
    phase(4'h7, 32'h3000, 32'hC4, 4'hF, 0, 0, R_DND, 0, 0, "R3 disc no data");
    phase(4'h7, 32'h3000, 32'hC4, 4'hF, 1, 0, R_RTY, 0, 0, "R4 retry after disconnect");
    // R4 partial drain still retried
    drain_en = 1'b1;
    @(posedge clk); #1;
    drain_en = 1'b0;
    phase(4'h7, 32'h3000, 32'hC4, 4'hF, 1, 0, R_RTY, 0, 0, "R4 retry after partial drain");
    chk(treq_n == 1'b0, "R5 treq held", 64'(treq_n), 0);
    drain_all();
    chk(treq_n == 1'b1, "R5 treq released", 64'(treq_n), 1);
    phase(4'h7, 32'h3004, 32'hC4, 4'hF, 1, 1, R_ACC, 1, 1, "R4 new transaction");
    drain_all();

    // R11 unclaimed command
    phase(4'h6, 32'h4000, 32'hD0, 4'hF, 1, 1, R_NONE, 0, 0, "R11 no response");
    chk(treq_n && !usr_wvalid && !usr_avalid, "R11 nothing pushed",
        64'({treq_n, usr_wvalid, usr_avalid}), 4);

    // R2 io write with delayed mode off
    phase(4'h3, 32'h0050, 32'hE0, 4'h1, 1, 1, R_ACC, 1, 1, "R2 io streaming");
    drain_all();

    // delayed mode
    delay_mode_n = 1'b0;
    phase(4'h7, 32'h5000, 32'hF0, 4'hF, 1, 1, R_ACC, 1, 1, "R12 mem still streams");
    drain_all();
    phase(4'h3, 32'h0060, 32'h1234, 4'h5, 1, 1, R_RTY, 1, 1, "R6 first attempt retry");
    chk(treq_n == 1'b0, "R6 treq low", 64'(treq_n), 0);
    chk(usr_wvalid && usr_avalid, "R6 captured", 64'({usr_wvalid, usr_avalid}), 3);
    phase(4'h3, 32'h0060, 32'h1234, 4'h5, 1, 1, R_RTY, 0, 0, "R7 matching retried");
    phase(4'h7, 32'h5000, 32'hF1, 4'hF, 1, 1, R_RTY, 0, 0, "R7 other write retried");
    drain_all();
    phase(4'h3, 32'h0060, 32'h1235, 4'h5, 1, 1, R_RTY, 0, 0, "R9 data mismatch");
    phase(4'h3, 32'h0060, 32'h1234, 4'h4, 1, 1, R_RTY, 0, 0, "R9 be mismatch");
    chk(treq_n == 1'b0, "R9 still pending", 64'(treq_n), 0);
    phase(4'h3, 32'h0060, 32'h1234, 4'h5, 1, 1, R_DD, 0, 0, "R8 completion");
    chk(treq_n == 1'b1, "R8 treq high", 64'(treq_n), 1);
    chk(!usr_wvalid && !usr_avalid, "R8 queues cleared", 64'({usr_wvalid, usr_avalid}), 0);

    // R10 discard timeout
    phase(4'h3, 32'h0070, 32'h5678, 4'hF, 1, 1, R_RTY, 1, 1, "R10 capture");
    for (int k = 1; k <= EXP_K + 1; k++) begin
      @(posedge clk); #2;
      if (k == EXP_K - 1) chk(tmr_expired == 1'b0, "R10 early", 64'(tmr_expired), 0);
      if (k == EXP_K)     chk(tmr_expired == 1'b1, "R10 pulse", 64'(tmr_expired), 1);
      if (k == EXP_K + 1) begin
        chk(tmr_expired == 1'b0, "R10 one cycle", 64'(tmr_expired), 0);
        chk(treq_n && !usr_wvalid && !usr_avalid, "R10 idle and cleared",
            64'({treq_n, usr_wvalid, usr_avalid}), 4);
      end
    end
    exp_wq.delete();
    exp_aq.delete();
    phase(4'h3, 32'h0070, 32'h5678, 4'hF, 1, 1, R_RTY, 1, 1, "R10 new request");
    chk(treq_n == 1'b0, "R10 treq low again", 64'(treq_n), 0);
    drain_all();
    phase(4'h3, 32'h0070, 32'h5678, 4'hF, 1, 1, R_DD, 0, 0, "R10 completes after restart");

    chk(exp_wq.size() == 0 && exp_aq.size() == 0, "R2 scoreboard empty",
        64'(exp_wq.size() + exp_aq.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule